// File: doc/BRIEF.md
# NAND Flash Command and Address Sequencer

This block sits between a flash driver's request logic and a lower engine that drives the flash bus cycle by cycle. It takes one high-level request and turns it into the ordered list of bus steps that the request needs. A request carries a command byte, a column (present or absent), a page address (present or absent), a flag for 2 KiB pages and a flag for high device density. The steps are command cycles, address cycles and buffer-area transfers. The block hands them to the engine one at a time over a valid/ready interface and waits for each one to complete before presenting the next.

The number of steps depends on the request. Page size sets the number of column cycles and the number of area transfers. Page size and density together set the number of page cycles. Large-page reads also get a confirm command between the address cycles and the data transfers. Column cycles always go out as zero. The requested column is kept on an output as the buffer index for the data path. The whole step list is planned when the request is accepted. After the last step completes, the block gives a one-cycle done pulse and becomes free for the next request.

Top module: `nand_cmd_seq`

## Requirements
- R1: When the column is marked present, the block emits address cycles of value 0x00 right after the command cycle: one for small pages and two for 2 KiB pages. Step kind encoding is 0 = command, 1 = address, 2 = data input (buffer to flash), 3 = data output (flash to buffer).
- R2: When the page is marked present, the page address cycles follow any column cycles. The first carries page bits 7:0 and the second carries bits 15:8.
- R3: On small-page devices, a third page cycle carrying bits 23:16 is emitted only when the density flag is set. The flag means a device size of at least 64 MiB.
- R4: On 2 KiB-page devices, the third page cycle is emitted only when the density flag is set. The flag means a device size of at least 256 MiB.
- R5: A read on a 2 KiB device (command 0x00 or 0x50) sends the confirm command 0x30 after the address cycles. It then sends four data-output steps whose data field is the buffer area 0, 1, 2, 3, in that order.
- R6: A read on a small-page device sends one data-output step for area 0 after the address cycles, with no confirm command.
- R7: A program request (command 0x10) sends data-input steps before the command cycle: area 0 only on small pages, and areas 0 to 3 in order on 2 KiB pages.
- R8: A spare read request (command 0x50) goes out as command 0x00 on 2 KiB devices and as 0x50 on small-page devices.
- R9: A request with both the column and the page marked absent emits only its command cycle.
- R10: After reset, req_ready is 1 and step_valid and done are 0. A request is accepted only while idle. done is high for exactly one cycle, the cycle after the last step's handshake.
- R11: While step_valid is high and step_ready is low, step_kind and step_data hold their values.
- R12: On acceptance, col_idx takes the requested column when the column is present, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_cmd | input | 8 | Command byte |
| req_col_en | input | 1 | Column present |
| req_col | input | COL_W | Requested column (buffer index) |
| req_page_en | input | 1 | Page address present |
| req_page | input | 24 | Page address |
| req_big | input | 1 | 2 KiB page device |
| req_dense | input | 1 | Device large enough for a third page cycle |
| col_idx | output | COL_W | Buffer index kept from the last request |
| step_valid | output | 1 | Step offered to the operation engine |
| step_ready | input | 1 | Engine has completed the offered step |
| step_kind | output | 2 | Step kind (0 cmd, 1 addr, 2 data in, 3 data out) |
| step_data | output | 8 | Command byte, address byte, or area number |
| done | output | 1 | One-cycle pulse after the last step |

## Verification
The bench builds the block with its defaults: four areas, a 16-entry step store and a 12-bit column. With these values the longest sequence, a dense large-page read of eleven steps, fits and is run both directed and at random. The engine side inserts random stalls, so every step is held across waits and the done pulse follows handshakes that come back to back as well as ones that are spread out. Random requests mix page size, density, the present flags and the spare-read and program commands, so each count of address cycles is reached under each page size.

// File: rtl/nandseq_pkg.sv
package nandseq_pkg;
  localparam int PAGE_W = 24;

  typedef enum logic [1:0] {
    K_CMD  = 2'd0,
    K_ADDR = 2'd1,
    K_DIN  = 2'd2,
    K_DOUT = 2'd3
  } step_kind_t;

  typedef struct packed {
    step_kind_t  kind;
    logic [7:0]  data;
  } step_t;

  localparam logic [7:0] OP_READ       = 8'h00;
  localparam logic [7:0] OP_READ_SPARE = 8'h50;
  localparam logic [7:0] OP_PROG       = 8'h10;
  localparam logic [7:0] OP_CONFIRM    = 8'h30;
endpackage

// File: rtl/nandseq_plan.sv
module nandseq_plan
  import nandseq_pkg::*;
#(
  parameter int AREAS     = 4,
  parameter int MAX_STEPS = 16,
  localparam int CNT_W    = $clog2(MAX_STEPS + 1)
) (
  input  logic [7:0]                  cmd,
  input  logic                        col_en,
  input  logic                        page_en,
  input  logic [PAGE_W-1:0]           page,
  input  logic                        big,
  input  logic                        dense,
  output step_t [MAX_STEPS-1:0]       plan,
  output logic [CNT_W-1:0]            len
);
  logic       is_read;
  logic       is_prog;
  logic [7:0] cmd_eff;

  always_comb begin
    is_read = (cmd == OP_READ) || (cmd == OP_READ_SPARE);
    is_prog = (cmd == OP_PROG);
    cmd_eff = (big && cmd == OP_READ_SPARE) ? OP_READ : cmd;
  end

  always_comb begin
    logic [CNT_W-1:0] n;
    n    = '0;
    plan = '0;
    // data-input transfers precede the program command
    if (is_prog) begin
      for (int a = 0; a < AREAS; a++) begin
        if (a == 0 || big) begin
          plan[n] = '{kind: K_DIN, data: 8'(a)};
          n = n + 1'b1;
        end
      end
    end
    plan[n] = '{kind: K_CMD, data: cmd_eff};
    n = n + 1'b1;
    if (col_en) begin
      plan[n] = '{kind: K_ADDR, data: 8'h00};
      n = n + 1'b1;
      if (big) begin
        plan[n] = '{kind: K_ADDR, data: 8'h00};
        n = n + 1'b1;
      end
    end
    if (page_en) begin
      plan[n] = '{kind: K_ADDR, data: page[7:0]};
      n = n + 1'b1;
      plan[n] = '{kind: K_ADDR, data: page[15:8]};
      n = n + 1'b1;
      if (dense) begin
        plan[n] = '{kind: K_ADDR, data: page[23:16]};
        n = n + 1'b1;
      end
    end
    if (is_read) begin
      if (big) begin
        plan[n] = '{kind: K_CMD, data: OP_CONFIRM};
        n = n + 1'b1;
      end
      for (int a = 0; a < AREAS; a++) begin
        if (a == 0 || big) begin
          plan[n] = '{kind: K_DOUT, data: 8'(a)};
          n = n + 1'b1;
        end
      end
    end
    len = n;
  end
endmodule

// File: rtl/nandseq_store.sv
module nandseq_store
  import nandseq_pkg::*;
#(
  parameter int MAX_STEPS = 16,
  localparam int IDX_W    = $clog2(MAX_STEPS)
) (
  input  logic                  clk,
  input  logic                  we,
  input  step_t [MAX_STEPS-1:0] wr_plan,
  input  logic [IDX_W-1:0]      rd_idx,
  output step_t                 rd_step
);
  step_t mem [MAX_STEPS];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int i = 0; i < MAX_STEPS; i++) mem[i] <= wr_plan[i];
    end
  end

  assign rd_step = mem[rd_idx];
endmodule

// File: rtl/nandseq_issue.sv
module nandseq_issue
  import nandseq_pkg::*;
#(
  parameter int MAX_STEPS = 16,
  localparam int IDX_W    = $clog2(MAX_STEPS),
  localparam int CNT_W    = $clog2(MAX_STEPS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  input  step_t            first,
  input  step_t            rd_step,
  output logic [IDX_W-1:0] rd_idx,
  input  logic             step_ready,
  output logic             step_valid,
  output step_t            step,
  output logic             busy,
  output logic             done
);
  logic [IDX_W-1:0] ptr;
  logic [CNT_W-1:0] total;
  logic [CNT_W-1:0] nxt;

  assign nxt    = CNT_W'(ptr) + 1'b1;
  assign rd_idx = IDX_W'(nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      step_valid <= 1'b0;
      done       <= 1'b0;
      ptr        <= '0;
      total      <= '0;
      step       <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy       <= 1'b1;
        step_valid <= 1'b1;
        step       <= first;
        ptr        <= '0;
        total      <= len;
      end else if (step_valid && step_ready) begin
        if (nxt < total) begin
          ptr  <= rd_idx;
          step <= rd_step;
        end else begin
          step_valid <= 1'b0;
          busy       <= 1'b0;
          done       <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nandseq_pkg::*;
#(
  parameter int COL_W     = 12,
  parameter int AREAS     = 4,
  parameter int MAX_STEPS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [7:0]        req_cmd,
  input  logic              req_col_en,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_page_en,
  input  logic [23:0]       req_page,
  input  logic              req_big,
  input  logic              req_dense,
  output logic [COL_W-1:0]  col_idx,
  output logic              step_valid,
  input  logic              step_ready,
  output logic [1:0]        step_kind,
  output logic [7:0]        step_data,
  output logic              done
);
  localparam int IDX_W = $clog2(MAX_STEPS);
  localparam int CNT_W = $clog2(MAX_STEPS + 1);

  step_t [MAX_STEPS-1:0] plan;
  logic [CNT_W-1:0]      len;
  logic                  busy;
  logic                  start;
  logic [IDX_W-1:0]      rd_idx;
  step_t                 rd_step;
  step_t                 step;

  assign req_ready = !busy;
  assign start     = req_valid && !busy;

  nandseq_plan #(.AREAS(AREAS), .MAX_STEPS(MAX_STEPS)) i_plan (
    .cmd(req_cmd), .col_en(req_col_en), .page_en(req_page_en),
    .page(req_page), .big(req_big), .dense(req_dense),
    .plan(plan), .len(len)
  );

  nandseq_store #(.MAX_STEPS(MAX_STEPS)) i_store (
    .clk(clk), .we(start), .wr_plan(plan),
    .rd_idx(rd_idx), .rd_step(rd_step)
  );

  nandseq_issue #(.MAX_STEPS(MAX_STEPS)) i_issue (
    .clk(clk), .rst(rst), .start(start), .len(len), .first(plan[0]),
    .rd_step(rd_step), .rd_idx(rd_idx), .step_ready(step_ready),
    .step_valid(step_valid), .step(step), .busy(busy), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst) col_idx <= '0;
    else if (start) col_idx <= req_col_en ? req_col : '0;
  end

  assign step_kind = step.kind;
  assign step_data = step.data;
endmodule

// File: rtl/nandseq_chk.sv
module nandseq_chk #(
  parameter int COL_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             step_valid,
  input logic             step_ready,
  input logic [1:0]       step_kind,
  input logic [7:0]       step_data,
  input logic             done
);
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready);  // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !step_valid);  // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R10
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(step_valid && step_ready));  // R10
  AST_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    step_valid && !step_ready |=> step_valid && $stable(step_kind) && $stable(step_data));  // R11
endmodule

bind nand_cmd_seq nandseq_chk #(.COL_W(COL_W)) i_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .step_valid(step_valid), .step_ready(step_ready), .step_kind(step_kind),
  .step_data(step_data), .done(done)
);

// File: tb/test_nand_cmd_seq.sv
module test_nand_cmd_seq;
  localparam int COL_W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [7:0] req_cmd = '0;
  logic req_col_en = 1'b0;
  logic [COL_W-1:0] req_col = '0;
  logic req_page_en = 1'b0;
  logic [23:0] req_page = '0;
  logic req_big = 1'b0;
  logic req_dense = 1'b0;
  logic [COL_W-1:0] col_idx;
  logic step_valid;
  logic step_ready = 1'b0;
  logic [1:0] step_kind;
  logic [7:0] step_data;
  logic done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [1:0] exp_kind [32];
  logic [7:0] exp_data [32];
  int exp_n;

  always #2 clk = ~clk;

  nand_cmd_seq #(.COL_W(COL_W)) i_nand_cmd_seq (.*);

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, expv);
    end
  endtask

  function automatic void push(logic [1:0] k, logic [7:0] d);
    exp_kind[exp_n] = k;
    exp_data[exp_n] = d;
    exp_n++;
  endfunction

  function automatic void model(logic [7:0] cmd, bit ce, bit pe, logic [23:0] pg,
                                bit big, bit dense);
    bit rd = (cmd == 8'h00) || (cmd == 8'h50);
    int areas = big ? 4 : 1;
    exp_n = 0;
    if (cmd == 8'h10) for (int a = 0; a < areas; a++) push(2'd2, 8'(a));
    push(2'd0, (big && cmd == 8'h50) ? 8'h00 : cmd);
    if (ce) begin
      push(2'd1, 8'h00);
      if (big) push(2'd1, 8'h00);
    end
    if (pe) begin
      push(2'd1, pg[7:0]);
      push(2'd1, pg[15:8]);
      if (dense) push(2'd1, pg[23:16]);
    end
    if (rd) begin
      if (big) push(2'd0, 8'h30);
      for (int a = 0; a < areas; a++) push(2'd3, 8'(a));
    end
  endfunction

  task automatic run(logic [7:0] cmd, bit ce, logic [COL_W-1:0] col, bit pe,
                     logic [23:0] pg, bit big, bit dense, string tag);
    int got = 0;
    bit prev_hs = 0;
    bit seen_done = 0;
    bit hold = 0;
    logic [1:0] hk = '0;
    logic [7:0] hd = '0;
    model(cmd, ce, pe, pg, big, dense);
    @(negedge clk);
    req_cmd = cmd; req_col_en = ce; req_col = col; req_page_en = pe;
    req_page = pg; req_big = big; req_dense = dense;
    req_valid = 1'b1; step_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10", "ready while busy", int'(req_ready), 0);
    chk(col_idx == (ce ? col : '0), "R12", "col_idx", int'(col_idx), int'(ce ? col : '0));
    for (int c = 0; c < 200 && !seen_done; c++) begin
      if (c > 0) @(negedge clk);
      if (done) begin
        seen_done = 1;
        chk(prev_hs, "R10", "done not right after last step", 0, 1);
        chk(got == exp_n, tag, "step count", got, exp_n);
        chk(req_ready == 1'b1, "R10", "ready after done", int'(req_ready), 1);
      end else begin
        if (hold && step_valid)
          chk(step_kind == hk && step_data == hd, "R11", "held step changed",
              {step_kind, step_data}, {hk, hd});
        step_ready = ($urandom % 3) != 0;
        #0.1;
        prev_hs = step_valid && step_ready;
        hold = step_valid && !step_ready;
        hk = step_kind; hd = step_data;
        if (prev_hs) begin
          if (got < exp_n)
            chk(step_kind == exp_kind[got] && step_data == exp_data[got], tag,
                $sformatf("step %0d kind/data", got),
                {step_kind, step_data}, {exp_kind[got], exp_data[got]});
          got++;
        end
      end
    end
    chk(seen_done, tag, "done never seen", 0, 1);
    @(negedge clk);
    step_ready = 1'b0;
    chk(done == 1'b0, "R10", "done longer than one cycle", int'(done), 0);
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "reset ready", int'(req_ready), 1);
    chk(step_valid == 1'b0, "R10", "reset step_valid", int'(step_valid), 0);
    chk(done == 1'b0, "R10", "reset done", int'(done), 0);

    run(8'hFF, 0, 12'h000, 0, 24'h0, 0, 0, "R9");
    run(8'h90, 1, 12'h000, 0, 24'h0, 0, 0, "R1");
    run(8'h90, 1, 12'h000, 0, 24'h0, 1, 0, "R1");
    run(8'h00, 1, 12'h123, 1, 24'hABCDEF, 0, 0, "R2");
    run(8'h00, 1, 12'h044, 1, 24'h123456, 0, 1, "R3");
    run(8'h00, 1, 12'h7FF, 1, 24'h654321, 1, 0, "R4");
    run(8'h00, 1, 12'h800, 1, 24'hFEDCBA, 1, 1, "R5");
    run(8'h00, 1, 12'h010, 1, 24'h00FF01, 0, 0, "R6");
    run(8'h10, 0, 12'h000, 0, 24'h0, 0, 0, "R7");
    run(8'h10, 0, 12'h000, 0, 24'h0, 1, 0, "R7");
    run(8'h50, 1, 12'h005, 1, 24'h000102, 1, 0, "R8");
    run(8'h50, 1, 12'h005, 1, 24'h000102, 0, 0, "R8");
    run(8'h60, 0, 12'h000, 1, 24'h0A0B0C, 1, 1, "R4");

    for (int i = 0; i < 300; i++) begin
      logic [7:0] cmds [6] = '{8'h00, 8'h50, 8'h10, 8'h70, 8'h60, 8'h90};
      run(cmds[$urandom % 6], 1'($urandom), 12'($urandom), 1'($urandom),
          24'($urandom), 1'($urandom), 1'($urandom), "R2");
    end
    finished = 1;
    summary();
  end
endmodule